// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block is the fixed-logic control unit of a small single-accumulator machine, together with the few registers it steers. These are a memory address register, a memory buffer register, the program counter, the instruction register and the accumulator. It drives a synchronous, word-addressed memory. The memory returns read data one clock after a read strobe. Every machine instruction is a chain of phases (fetch, optional indirect, execute, optional interrupt). A 2-bit phase code names the current phase. Inside each phase, a step counter walks through the timed register-transfer steps t1 to t4.

An instruction word is 16 bits. Bit 15 marks indirect addressing, bits 14..12 carry the opcode and bits 11..0 hold the address. The machine has three real operations. Opcode 000 adds a memory word to the accumulator. Opcode 001 increments a memory word and skips the next instruction when the result is zero. Opcode 010 stores the return address at X and continues at X+1. Every other opcode is a one-step no-op. An interrupt request is honoured only at the end of an execute phase, and only while the interrupt-enable flag is set. A one-cycle pulse on `ie_set` sets that flag, and entering the interrupt phase clears it.

Top module: `hw_cycle_ctrl`

## Requirements
- R1: `cycle_code` encodes fetch as 00, indirect as 01, execute as 10 and interrupt as 11. After fetch comes indirect when bit 15 of the fetched word is 1, otherwise execute. After indirect comes execute. After interrupt comes fetch.
- R2: `step` counts 0..3 for t1..t4 and returns to 0 whenever `cycle_code` changes. Fetch, indirect and interrupt each last exactly 3 steps.
- R3: Fetch reads the word at PC in t1 and increments PC in t2. A direct instruction therefore starts its fetch t1 with `pc` equal to its own address.
- R4: Indirect reads the word at the address field and replaces IR bits 11..0 with bits 11..0 of that word. An indirect ADD therefore takes 9 cycles from fetch t1 to the next fetch t1.
- R5: Opcode 000 (ADD X) sets the accumulator to accumulator + M[X] modulo 2^16 in t3. A direct ADD takes 6 cycles.
- R6: Opcode 001 (ISZ X) writes M[X]+1 back to X in t4 and increments PC in that same step when the result is 0. The instruction takes 7 cycles.
- R7: Opcode 010 (BSA X) writes the address of the following instruction to M[X], and the next fetch starts at X+1 after 6 cycles.
- R8: Opcodes 011 to 111 have a one-step execute phase with no memory access and no register effect, so they take 4 cycles.
- R9: When an execute phase ends with `irq` high and interrupt enable set, the interrupt phase follows. It writes the PC to SAVE_ADDR, loads PC with VECTOR_ADDR and clears interrupt enable. With enable clear, `irq` has no effect.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. Read data is taken on the step after `mem_rd`.
- R11: While `rst_n` is low: `cycle_code` = 00, `step` = 0, `pc` = 0, `acc` = 0, and interrupt enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| ie_set | input | 1 | Sets the interrupt-enable flag |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd` |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| cycle_code | output | 2 | Current phase code |
| step | output | 2 | Current timing step (0 = t1) |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |

## Verification
The embedded assertions check several rules on every cycle. Reads and writes to memory never coincide. The step counter restarts on every phase change, and only execute ever reaches t4. Fetch always bumps PC, indirect always hands over to execute, the ADD step sums correctly, and interrupt entry leaves enable clear. Some behaviour can only be shown by the bench's programs, run against its memory model. This covers memory contents after ISZ and BSA writes, the skip decision, the cycle length of each instruction form, the saved return address, and the fact that a second request is ignored once enable has been cleared.

// File: rtl/hw_cycle_ctrl.sv
module hw_cycle_ctrl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] SAVE_ADDR   = 12'hFF0,
  parameter logic [AW-1:0] VECTOR_ADDR = 12'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic          ie_set,
  input  logic [AW+3:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW+3:0] mem_wdata,
  output logic [1:0]    cycle_code,
  output logic [1:0]    step,
  output logic [AW-1:0] pc,
  output logic [AW+3:0] acc
);
  localparam int DW = AW + 4;
  localparam logic [1:0] PH_FET = 2'b00, PH_IND = 2'b01, PH_EXE = 2'b10, PH_INT = 2'b11;
  localparam logic [2:0] OP_ADD = 3'b000, OP_ISZ = 3'b001, OP_BSA = 3'b010;

  logic [1:0]    ph_q, st_q, ph_d;
  logic [AW-1:0] mar_q, pc_q;
  logic [DW-1:0] mbr_q, ir_q, acc_q;
  logic          ie_q;

  wire [2:0]    opc    = ir_q[DW-2:AW];
  wire [AW-1:0] afield = ir_q[AW-1:0];
  wire is_f = ph_q == PH_FET;
  wire is_i = ph_q == PH_IND;
  wire is_e = ph_q == PH_EXE;
  wire is_n = ph_q == PH_INT;
  wire e_add = is_e && opc == OP_ADD;
  wire e_isz = is_e && opc == OP_ISZ;
  wire e_bsa = is_e && opc == OP_BSA;
  wire e_nop = is_e && !(e_add || e_isz || e_bsa);

  wire phase_end = ((is_f || is_i || is_n || e_add || e_bsa) && st_q == 2'd2) ||
                   (e_isz && st_q == 2'd3) || (e_nop && st_q == 2'd0);
  wire take_int  = is_e && phase_end && irq && ie_q;

  always_comb begin
    ph_d = ph_q;
    if (phase_end) begin
      case (ph_q)
        PH_FET:  ph_d = mbr_q[DW-1] ? PH_IND : PH_EXE;
        PH_IND:  ph_d = PH_EXE;
        PH_EXE:  ph_d = take_int ? PH_INT : PH_FET;
        default: ph_d = PH_FET;
      endcase
    end
  end

  assign mem_rd    = (is_f || is_i || e_add || e_isz) && st_q == 2'd0;
  assign mem_wr    = (is_n && st_q == 2'd2) || (e_isz && st_q == 2'd3) || (e_bsa && st_q == 2'd1);
  assign mem_addr  = mem_rd ? (is_f ? pc_q : afield) : mar_q;
  assign mem_wdata = mbr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_FET;
      st_q  <= 2'd0;
      mar_q <= '0;
      pc_q  <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      st_q <= phase_end ? 2'd0 : st_q + 2'd1;
      if (take_int)    ie_q <= 1'b0;
      else if (ie_set) ie_q <= 1'b1;

      if (mem_rd) mar_q <= mem_addr;
      if (is_n && st_q == 2'd1) mar_q <= SAVE_ADDR;
      if (e_bsa && st_q == 2'd0) mar_q <= afield;

      if ((is_f || is_i || e_add || e_isz) && st_q == 2'd1) mbr_q <= mem_rdata;
      if (e_isz && st_q == 2'd2) mbr_q <= mbr_q + 1'b1;
      if ((e_bsa || is_n) && st_q == 2'd0) mbr_q <= {{(DW-AW){1'b0}}, pc_q};

      if (is_f && st_q == 2'd1) pc_q <= pc_q + 1'b1;
      if (e_isz && st_q == 2'd3 && mbr_q == '0) pc_q <= pc_q + 1'b1;
      if (e_bsa && st_q == 2'd1) pc_q <= afield;
      if (e_bsa && st_q == 2'd2) pc_q <= pc_q + 1'b1;
      if (is_n && st_q == 2'd1) pc_q <= VECTOR_ADDR;

      if (is_f && st_q == 2'd2) ir_q <= mbr_q;
      if (is_i && st_q == 2'd2) ir_q[AW-1:0] <= mbr_q[AW-1:0];

      if (e_add && st_q == 2'd2) acc_q <= acc_q + mbr_q;
    end
  end

  assign cycle_code = ph_q;
  assign step       = st_q;
  assign pc         = pc_q;
  assign acc        = acc_q;

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R10
  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> st_q == 2'd0); // R2
  AST_T4_ONLY_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == 2'd3) |-> ph_q == PH_EXE); // R2
  AST_FETCH_PC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_f && st_q == 2'd1) |=> pc_q == $past(pc_q) + 1'b1); // R3
  AST_IND_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_i && st_q == 2'd2) |=> ph_q == PH_EXE); // R1
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (e_add && st_q == 2'd2) |=> acc_q == $past(acc_q) + $past(mbr_q)); // R5
  AST_INT_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_n && st_q == 2'd0) |-> !ie_q); // R9
  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_n && st_q == 2'd1) |=> pc_q == VECTOR_ADDR && mar_q == SAVE_ADDR); // R9
endmodule

// File: tb/hw_cycle_ctrl_test.sv
module hw_cycle_ctrl_test;
  logic clk = 0, rst_n = 0, irq = 0, ie_set = 0;
  logic [15:0] mem_rdata, mem_wdata, acc;
  logic [11:0] mem_addr, pc;
  logic mem_rd, mem_wr;
  logic [1:0] cycle_code, step;

  hw_cycle_ctrl uut (.clk(clk), .rst_n(rst_n), .irq(irq), .ie_set(ie_set),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .cycle_code(cycle_code), .step(step), .pc(pc), .acc(acc));

  always #5 clk = ~clk;

  logic [15:0] mem [0:4095];
  logic clr = 0, ld_we = 0;
  logic [11:0] ld_addr = 0;
  logic [15:0] ld_data = 0;
  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 16'h7000;
    end else if (ld_we) mem[ld_addr] <= ld_data;
    else begin
      if (mem_rd) mem_rdata <= mem[mem_addr];
      if (mem_wr) mem[mem_addr] <= mem_wdata;
    end
  end

  int cyc, nrec, nint;
  int rec_cyc [16];
  logic [11:0] rec_pc [16];
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; nrec = 0; nint = 0;
    end else begin
      if (cycle_code == 2'b00 && step == 2'd0 && nrec < 16) begin
        rec_cyc[nrec] = cyc; rec_pc[nrec] = pc; nrec++;
      end
      if (cycle_code == 2'b11 && step == 2'd0) nint++;
      cyc++;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_run();
    rst_n = 0; clr = 1;
    @(posedge clk); #1 clr = 0;
  endtask
  task automatic load(input logic [11:0] a, input logic [15:0] d);
    ld_we = 1; ld_addr = a; ld_data = d;
    @(posedge clk); #1 ld_we = 0;
  endtask
  task automatic go(input int n);
    @(posedge clk); #1 rst_n = 1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    begin_run();
    chk("R11 cycle_code", cycle_code, 0);
    chk("R11 step", step, 0);
    chk("R11 pc", pc, 0);
    chk("R11 acc", acc, 0);

    // Mixed program: direct ADD, indirect ADD, ISZ no skip, NOP, BSA
    begin_run();
    load(12'h000, 16'h0100); load(12'h100, 16'h1234);
    load(12'h001, 16'h8101); load(12'h101, 16'h0102); load(12'h102, 16'h0F0F);
    load(12'h002, 16'h1103); load(12'h103, 16'h0005);
    load(12'h003, 16'h7000);
    load(12'h004, 16'h2200);
    go(40);
    chk("R3 first pc", rec_pc[0], 12'h000);
    chk("R3 pc after ADD", rec_pc[1], 12'h001);
    chk("R5 ADD length", rec_cyc[1] - rec_cyc[0], 6);
    chk("R4 indirect ADD length", rec_cyc[2] - rec_cyc[1], 9);
    chk("R1 pc after indirect", rec_pc[2], 12'h002);
    chk("R6 ISZ length", rec_cyc[3] - rec_cyc[2], 7);
    chk("R6 ISZ no skip pc", rec_pc[3], 12'h003);
    chk("R8 NOP length", rec_cyc[4] - rec_cyc[3], 4);
    chk("R8 NOP pc", rec_pc[4], 12'h004);
    chk("R7 BSA length", rec_cyc[5] - rec_cyc[4], 6);
    chk("R7 BSA resume X+1", rec_pc[5], 12'h201);
    chk("R7 BSA saved return", mem[12'h200], 16'h0005);
    chk("R6 ISZ written value", mem[12'h103], 16'h0006);
    chk("R4 R5 acc sum", acc, 16'h1234 + 16'h0F0F);
    chk("R9 no interrupt without request", nint, 0);

    // R6 skip on zero
    begin_run();
    load(12'h000, 16'h1103); load(12'h103, 16'hFFFF);
    load(12'h001, 16'h0100); load(12'h100, 16'h0007);
    go(20);
    chk("R6 skip pc", rec_pc[1], 12'h002);
    chk("R6 skip timing", rec_cyc[1], 7);
    chk("R6 wrap to zero", mem[12'h103], 16'h0000);
    chk("R6 skipped ADD had no effect", acc, 16'h0000);

    // R5 sweep: twelve ADDs, three data sets
    for (int s = 0; s < 3; s++) begin
      logic [15:0] expsum;
      expsum = 0;
      begin_run();
      for (int i = 0; i < 12; i++) begin
        logic [15:0] v;
        v = 16'(i * 16'h1357 + s * 16'h0F0F + 16'hA5A5);
        expsum = expsum + v;
        load(12'(i), 16'(12'h300 + i));
        load(12'(12'h300 + i), v);
      end
      go(12 * 6 + 4);
      chk("R5 ADD sweep sum", acc, expsum);
    end

    // R9 interrupt taken, enable cleared afterwards
    begin_run();
    load(12'h000, 16'h0100); load(12'h100, 16'h0003);
    irq = 1;
    @(posedge clk); #1 rst_n = 1; ie_set = 1;
    @(posedge clk); #1 ie_set = 0;
    repeat (40) @(posedge clk);
    #1;
    chk("R9 interrupt entries", nint, 1);
    chk("R9 handler fetch pc", rec_pc[1], 12'h800);
    chk("R1 R2 interrupt phase length", rec_cyc[1], 9);
    chk("R9 saved pc", mem[12'hFF0], 16'h0001);
    chk("R9 enable cleared, next pc", rec_pc[2], 12'h801);
    chk("R9 acc kept", acc, 16'h0003);

    // R9 request ignored while enable clear
    begin_run();
    load(12'h000, 16'h0100); load(12'h100, 16'h0003);
    irq = 1;
    go(30);
    chk("R9 ignored without enable", nint, 0);
    chk("R9 sequential pc", rec_pc[1], 12'h001);
    irq = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule